// File: doc/BRIEF.md
# Serial Register Write Slave with Deferred Commit

This block accepts register writes over a three-wire serial link: a shift clock, a data line and an active-low load line. A frame opens when the load line falls. Its first eight bits carry an address and the following bits carry 24-bit data words. Each field is shifted in starting from its least significant bit. When the load line stays low past the first word, every further word goes to the next address up, so a whole run of registers can be loaded from one address.

Complete words land in a shadow array of 256 entries of 24 bits. A separate active array, which the surrounding logic reads through a parallel lookup port, is loaded from the shadow array in one step at a commit point. A control register inside the address space selects one of two commit points. The first is the rising edge of the load line. The second is a chosen line-sync falling edge counted from the next frame-sync falling edge, so that new settings never change in the middle of a video field.

All serial and sync inputs are sampled by the system clock through synchronisers. Edges are detected in the system clock domain, so the serial clock has to run well below the system clock.

Top module: `serwr_regfile`

## Requirements
- R1: While ser_load_n is low, ser_din is sampled on each rising edge of ser_clk. The first 8 bits form the address and the following 24 bits form a data word, each least significant bit first.
- R2: After a 32-bit frame in immediate mode, rd_data at that address returns the written word.
- R3: Toggling ser_clk while ser_load_n is high changes no register. Each low period of ser_load_n starts afresh with an 8-bit address.
- R4: A data word cut short by ser_load_n rising before its 24th bit is discarded, and its register keeps its previous value. Complete words before it in the same frame are still written.
- R5: Each further complete word in the same frame is written to the previous address plus one, and address 255 is followed by address 0.
- R6: After reset every active register reads zero. The active array changes only at a commit point.
- R7: Address 0x80 is the control register. Bit 0 set selects synchronised mode. Bits 12:1 hold a line count N. The control value takes effect at the ser_load_n rising edge that ends its frame, and the commit of that frame follows the mode that was in force before.
- R8: In immediate mode, the active array takes the shadow contents a few system clocks after the ser_load_n rising edge of any frame that completed at least one word.
- R9: In synchronised mode, the commit happens at the (N+1)-th falling edge of line_sync after the first falling edge of frame_sync that follows the frame's end. Falling edges of line_sync before that frame_sync edge commit nothing.
- R10: Bits 23:13 of the control word are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, data taken on its rising edge |
| ser_din | input | 1 | Serial data line |
| ser_load_n | input | 1 | Active-low frame select; its rising edge ends a frame |
| frame_sync | input | 1 | Field sync; its falling edge arms the deferred commit |
| line_sync | input | 1 | Line sync; its falling edges are counted for the deferred commit |
| rd_addr | input | 8 | Lookup address into the active array |
| rd_data | output | 24 | Active register contents at rd_addr |

## Verification
The embedded properties check several rules on every clock. A word is only ever produced from a bit taken while the load line was low. Words inside one frame always carry consecutive addresses. A commit only follows a load-line rise or a line-sync fall, and never comes out of the state that waits for frame sync. The lookup output holds steady between commits. Other behaviours only show at the ports over whole scenarios, so the bench has to drive them: least-significant-bit-first field order, address wrap, dropping of partial words, the counted line-sync delay, and a mode change that applies only from the following frame.

// File: rtl/serwr_pkg.sv
package serwr_pkg;
    localparam int AW  = 8;
    localparam int DW  = 24;
    localparam int HDW = 12;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_t;

    typedef struct packed {
        logic           sync_en;
        logic [HDW-1:0] line_cnt;
    } ctrl_t;

    typedef enum logic [1:0] {
        CM_IDLE    = 2'd0,
        CM_WAIT_FS = 2'd1,
        CM_COUNT   = 2'd2
    } cm_state_e;

    function automatic ctrl_t decode_ctrl(input logic [DW-1:0] w);
        ctrl_t c;
        c.sync_en  = w[0];
        c.line_cnt = w[HDW:1];
        return c;
    endfunction
endpackage

// File: rtl/serwr_sync.sv
module serwr_sync #(
    parameter int N      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '1;
            else     sh <= {sh[STAGES-2:0], din[i]};
        end
        assign lvl[i] = sh[STAGES-1];
    end
endmodule

// File: rtl/serwr_rx.sv
module serwr_rx
    import serwr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clk_rise,
    input  logic load_hi,
    input  logic din,
    output wr_t  wr
);
    localparam int ACW = $clog2(AW);
    localparam int DCW = $clog2(DW);
    localparam logic [ACW-1:0] ALAST = ACW'(AW - 1);
    localparam logic [DCW-1:0] DLAST = DCW'(DW - 1);

    logic           addr_done;
    logic [ACW-1:0] acnt;
    logic [DCW-1:0] dcnt;
    logic [AW-1:0]  addr_sh;
    logic [DW-1:0]  dat_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_done <= 1'b0;
            acnt      <= '0;
            dcnt      <= '0;
            addr_sh   <= '0;
            dat_sh    <= '0;
            wr        <= '0;
        end else begin
            wr.en <= 1'b0;
            if (load_hi) begin
                addr_done <= 1'b0;
                acnt      <= '0;
                dcnt      <= '0;
            end else if (clk_rise) begin
                if (!addr_done) begin
                    addr_sh <= {din, addr_sh[AW-1:1]};
                    if (acnt == ALAST) begin
                        addr_done <= 1'b1;
                        acnt      <= '0;
                    end else begin
                        acnt <= acnt + 1'b1;
                    end
                end else begin
                    dat_sh <= {din, dat_sh[DW-1:1]};
                    if (dcnt == DLAST) begin
                        dcnt    <= '0;
                        wr.en   <= 1'b1;
                        wr.addr <= addr_sh;
                        wr.data <= {din, dat_sh[DW-1:1]};
                        addr_sh <= addr_sh + 1'b1;
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end
            end
        end
    end

    logic          seen_q;
    logic [AW-1:0] last_q;
    always_ff @(posedge clk) begin
        if (rst || load_hi) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (wr.en) begin
            seen_q <= 1'b1;
            last_q <= wr.addr;
        end
    end

    // R3
    word_from_low_chk: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> $past(!load_hi && clk_rise));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.en && seen_q && !load_hi) |-> (wr.addr == last_q + 1'b1));
endmodule

// File: rtl/serwr_commit.sv
module serwr_commit
    import serwr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_rise,
    input  logic  frame_words,
    input  logic  fs_fall,
    input  logic  ls_fall,
    input  ctrl_t ctrl,
    output logic  commit
);
    cm_state_e      state;
    logic [HDW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CM_IDLE;
            cnt    <= '0;
            commit <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (load_rise && frame_words && !ctrl.sync_en) begin
                commit <= 1'b1;
                state  <= CM_IDLE;
            end else begin
                unique case (state)
                    CM_IDLE: if (load_rise && frame_words) state <= CM_WAIT_FS;
                    CM_WAIT_FS: if (fs_fall) begin
                        state <= CM_COUNT;
                        cnt   <= '0;
                    end
                    CM_COUNT: if (ls_fall) begin
                        if (cnt == ctrl.line_cnt) begin
                            commit <= 1'b1;
                            state  <= CM_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= CM_IDLE;
                endcase
            end
        end
    end

    // R8
    commit_cause_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(load_rise || ls_fall));

    // R9
    no_commit_waiting_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && $past(state == CM_WAIT_FS)) |-> $past(load_rise));

    // R9
    counted_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && !$past(load_rise)) |-> $past(state == CM_COUNT && ls_fall));
endmodule

// File: rtl/serwr_regfile.sv
module serwr_regfile
    import serwr_pkg::*;
#(
    parameter logic [7:0] CTRL_ADDR   = 8'h80,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_clk,
    input  logic        ser_din,
    input  logic        ser_load_n,
    input  logic        frame_sync,
    input  logic        line_sync,
    input  logic [7:0]  rd_addr,
    output logic [23:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [4:0] lvl;
    logic [3:0] prev;
    serwr_sync #(.N(5), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({line_sync, frame_sync, ser_load_n, ser_din, ser_clk}),
        .lvl (lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= {lvl[4], lvl[3], lvl[2], lvl[0]};
    end

    logic sclk_rise, load_rise, fs_fall, ls_fall;
    assign sclk_rise = lvl[0] & ~prev[0];
    assign load_rise = lvl[2] & ~prev[1];
    assign fs_fall   = ~lvl[3] & prev[2];
    assign ls_fall   = ~lvl[4] & prev[3];

    wr_t wr;
    serwr_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .clk_rise (sclk_rise),
        .load_hi  (lvl[2]),
        .din      (lvl[1]),
        .wr       (wr)
    );

    logic  words_seen;
    logic  ctrl_dirty;
    ctrl_t ctrl_q, ctrl_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            words_seen <= 1'b0;
            ctrl_dirty <= 1'b0;
            ctrl_q     <= '0;
            ctrl_nxt   <= '0;
        end else begin
            if (load_rise) begin
                words_seen <= 1'b0;
                if (ctrl_dirty) begin
                    ctrl_q     <= ctrl_nxt;
                    ctrl_dirty <= 1'b0;
                end
            end
            if (wr.en) begin
                words_seen <= 1'b1;
                if (wr.addr == CTRL_ADDR) begin
                    ctrl_nxt   <= decode_ctrl(wr.data);
                    ctrl_dirty <= 1'b1;
                end
            end
        end
    end

    logic commit;
    serwr_commit u_commit (
        .clk         (clk),
        .rst         (rst),
        .load_rise   (load_rise),
        .frame_words (words_seen | wr.en),
        .fs_fall     (fs_fall),
        .ls_fall     (ls_fall),
        .ctrl        (ctrl_q),
        .commit      (commit)
    );

    logic [DW-1:0] shadow [DEPTH];
    logic [DW-1:0] active [DEPTH];

    always_ff @(posedge clk) begin
        if (rst)        shadow <= '{default: '0};
        else if (wr.en) shadow[wr.addr] <= wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst)         active <= '{default: '0};
        else if (commit) active <= shadow;
    end

    assign rd_data = active[rd_addr];

    // R6
    hold_between_commits_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(commit) && $stable(rd_addr)) |-> $stable(rd_data));

    // R7
    ctrl_at_load_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_q) |-> $past(load_rise));
endmodule

// File: tb/sim_serwr_regfile.sv
module sim_serwr_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_din = 1'b0;
    logic        ser_load_n = 1'b1;
    logic        frame_sync = 1'b1;
    logic        line_sync = 1'b1;
    logic [7:0]  rd_addr = 8'h00;
    logic [23:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serwr_regfile u0 (
        .clk        (clk),
        .rst        (rst),
        .ser_clk    (ser_clk),
        .ser_din    (ser_din),
        .ser_load_n (ser_load_n),
        .frame_sync (frame_sync),
        .line_sync  (line_sync),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    localparam int NT = 6;
    localparam logic [7:0]  T_A [NT] = '{8'h00, 8'h01, 8'h7F, 8'h55, 8'hAA, 8'hFD};
    localparam logic [23:0] T_D [NT] = '{24'h000001, 24'h800000, 24'hA5A5A5,
                                         24'h123456, 24'hFEDCBA, 24'h0F0F0F};

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        ser_din = b;
        wait_clk(3);
        ser_clk = 1'b1;
        wait_clk(3);
        ser_clk = 1'b0;
    endtask

    // ndata: number of data bits sent after the address (words w0, w1, w2 in turn)
    task automatic send_frame(input logic [7:0] a, input logic [23:0] w0,
                              input logic [23:0] w1, input logic [23:0] w2, input int ndata);
        logic [23:0] w;
        ser_load_n = 1'b0;
        wait_clk(3);
        for (int i = 0; i < 8; i++) put_bit(a[i]);
        for (int i = 0; i < ndata; i++) begin
            w = (i < 24) ? w0 : (i < 48) ? w1 : w2;
            put_bit(w[i % 24]);
        end
        wait_clk(3);
        ser_load_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic fs_pulse();
        frame_sync = 1'b0; wait_clk(6); frame_sync = 1'b1; wait_clk(6);
    endtask

    task automatic ls_pulse();
        line_sync = 1'b0; wait_clk(6); line_sync = 1'b1; wait_clk(6);
    endtask

    task automatic check(input string req, input logic [7:0] a, input logic [23:0] exp);
        rd_addr = a;
        wait_clk(1);
        n_chk++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%02h actual=%06h expected=%06h", req, a, rd_data, exp);
        end
    endtask

    initial begin
        wait_clk(8);
        rst = 1'b0;
        wait_clk(4);

        // R6: reset state
        check("R6", 8'h00, 24'h0);
        check("R6", 8'hFF, 24'h0);
        check("R6", 8'h80, 24'h0);

        // R1 R2: single-register frames from the table
        for (int k = 0; k < NT; k++) begin
            send_frame(T_A[k], T_D[k], 24'h0, 24'h0, 24);
            check("R2", T_A[k], T_D[k]);
        end
        check("R1", 8'h00, 24'h000001);

        // R3: clock toggles with load high, then a fresh frame
        for (int i = 0; i < 12; i++) put_bit(1'b1);
        wait_clk(10);
        check("R3", 8'hFF, 24'h0);
        check("R3", 8'h00, 24'h000001);
        send_frame(8'h10, 24'h00ABCD, 24'h0, 24'h0, 24);
        check("R3", 8'h10, 24'h00ABCD);

        // R5: auto-increment across three words with wrap
        send_frame(8'hFE, 24'h111111, 24'h222222, 24'h333333, 72);
        check("R5", 8'hFE, 24'h111111);
        check("R5", 8'hFF, 24'h222222);
        check("R5", 8'h00, 24'h333333);

        // R4: second word cut after 10 bits is dropped
        send_frame(8'h20, 24'h0C0FFE, 24'hFFFFFF, 24'h0, 34);
        check("R4", 8'h20, 24'h0C0FFE);
        check("R4", 8'h21, 24'h0);
        // R4: only word of a frame cut after 20 bits
        send_frame(8'h01, 24'h777777, 24'h0, 24'h0, 20);
        check("R4", 8'h01, 24'h800000);

        // R7 R10: control write with junk in upper bits, sync off
        send_frame(8'h80, 24'hFFE000, 24'h0, 24'h0, 24);
        check("R10", 8'h80, 24'hFFE000);
        send_frame(8'h30, 24'h000030, 24'h0, 24'h0, 24);
        check("R10", 8'h30, 24'h000030);

        // R7: switch to synchronised mode, N = 2 (bits 12:1 = 2, bit 0 = 1 -> 0x000005)
        send_frame(8'h80, 24'h000005, 24'h0, 24'h0, 24);
        check("R7", 8'h80, 24'h000005);

        // R9: deferred commit
        send_frame(8'h40, 24'h404040, 24'h0, 24'h0, 24);
        check("R9", 8'h40, 24'h0);
        ls_pulse();
        check("R9", 8'h40, 24'h0);
        fs_pulse();
        check("R9", 8'h40, 24'h0);
        ls_pulse();
        ls_pulse();
        check("R9", 8'h40, 24'h0);
        ls_pulse();
        check("R9", 8'h40, 24'h404040);

        // R7: back to immediate; that frame still commits the old way
        send_frame(8'h80, 24'h000000, 24'h0, 24'h0, 24);
        check("R7", 8'h80, 24'h000005);
        // R8: next frame commits at load rise
        send_frame(8'h41, 24'h414141, 24'h0, 24'h0, 24);
        check("R8", 8'h41, 24'h414141);
        check("R8", 8'h80, 24'h000000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule